// File: doc/BRIEF.md
# PLL and Bus Clock Frequency Calculator

This block works out three clock rates in hertz from static configuration words: the input reference, the high-speed PLL output and the peripheral bus clock. Its inputs are a strap word, a PLL parameter word, a clock-select word and a chip-variant select. The two variants use different PLL parameter layouts and different fixed bus dividers. Every division is a truncating integer division. All divisions run on one shared 32-iteration restoring divider, so a calculation takes tens of cycles and needs no combinational divide.

A full calculation starts by itself when reset is released, and again on each `start_full` pulse. It recomputes all three rates. A `start_bus` pulse marks a clock-select update: it recomputes only the bus rate and reuses the PLL rate already held. `busy` is high while a calculation runs. `done` pulses for one cycle when all outputs are valid. The outputs then hold until the next calculation writes them.

Top module: `clkfreq_calc`

## Requirements
- R1: While reset is asserted, `ref_hz`, `pll_hz`, `bus_hz`, `busy` and `done` are 0. When reset is released, a full calculation runs without any start pulse and ends with a `done` pulse.
- R2: The reference is 25,000,000 when strap bit 23 is set. Otherwise it is 48,000,000 when strap bit 18 is set, and 24,000,000 when neither bit is set.
- R3: Variant 0 (`variant`=0): when PLL word bit 17 is set, `pll_hz` is 0, whatever the other bits hold.
- R4: Variant 0, bit 17 clear and bit 19 set: the multiplier is 1 when bit 18 is set. Otherwise it is (2 - bit4) * ((bits[10:5] + 2) / (bits[3:0] + 1)), with truncating division.
- R5: Variant 0, bits 17 and 19 clear: `pll_hz` comes from a table indexed by strap bits [9:8] (index 0 to 3). With a 24 or 48 MHz reference the values are 384, 360, 336 and 408 MHz. With a 25 MHz reference they are 400, 375, 350 and 425 MHz.
- R6: Variant 1: when bit 19 is set, `pll_hz` is 0. Otherwise, when bit 20 is set, the multiplier is 1. Otherwise the multiplier is ((bits[12:5] + 1) / (bits[4:0] + 1)) / (bits[18:13] + 1), truncating at each step.
- R7: Outside the table case, `pll_hz` equals the reference times the multiplier, taken modulo 2^32.
- R8: `bus_hz` equals (`pll_hz` / (clock-select bits[25:23] + 1)), then divided by 2 for variant 0 or by 4 for variant 1, truncating at each step.
- R9: `start_bus` recomputes `bus_hz` from the held `pll_hz` and the current clock-select word. `pll_hz` and `ref_hz` keep their values, and changes to the PLL word or the strap word have no effect.
- R10: A start pulse that arrives while `busy` is high is ignored. When both starts arrive together, the full calculation runs.
- R11: `busy` is high from the cycle after an accepted start until the calculation ends. `done` is a single-cycle pulse and coincides with `busy` falling. `bus_hz` changes only in a `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_full | input | 1 | Pulse: recompute reference, PLL and bus rates |
| start_bus | input | 1 | Pulse: recompute the bus rate only |
| variant | input | 1 | Chip variant select, sampled on an accepted start |
| strap_word | input | 32 | Strap configuration word |
| pll_word | input | 32 | PLL parameter word |
| clksel_word | input | 32 | Clock-select word carrying the bus divider field |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle pulse when all results are valid |
| ref_hz | output | 32 | Reference frequency in Hz |
| pll_hz | output | 32 | PLL output frequency in Hz |
| bus_hz | output | 32 | Bus clock frequency in Hz |

## Verification
The assertions check the handshake on every cycle. They confirm that `done` lasts one cycle and marks the fall of `busy`, that an accepted start raises `busy`, that `bus_hz` moves only on `done`, that `pll_hz` moves only during a calculation, and that a finished reference is always one of the three legal rates. The arithmetic can only be shown by the bench's scenarios. These cover the variant formulas and their truncation, the table fallback, product wrap-around, the bus-only path that keeps the held PLL rate, and starts that are dropped while the block is busy.

// File: rtl/clkfreq_calc.sv
module clkfreq_calc #(
  parameter int W             = 32,
  parameter int V0_OFF_BIT    = 17,
  parameter int V0_BYPASS_BIT = 18,
  parameter int V0_PROG_BIT   = 19,
  parameter int V1_OFF_BIT    = 19,
  parameter int V1_BYPASS_BIT = 20,
  parameter int REF25_BIT     = 23,
  parameter int REF48_BIT     = 18,
  parameter int HSEL_LSB      = 8,
  parameter int CLKDIV_LSB    = 23,
  parameter int CLKDIV_W      = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_full,
  input  logic         start_bus,
  input  logic         variant,
  input  logic [W-1:0] strap_word,
  input  logic [W-1:0] pll_word,
  input  logic [W-1:0] clksel_word,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] ref_hz,
  output logic [W-1:0] pll_hz,
  output logic [W-1:0] bus_hz
);

  localparam int CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  typedef enum logic [1:0] {S_IDLE, S_PLL, S_DIV, S_BUS} state_t;
  typedef enum logic [1:0] {PH_A, PH_B, PH_BUS} phase_t;

  state_t state;
  phase_t phase;
  logic kick;
  logic variant_q, s25_q, s48_q;
  logic [1:0] hsel_q;
  logic [W-1:0] pll_q;
  logic [CLKDIV_W-1:0] div_q;
  logic [W-1:0] quo_q, rem_q, den_q;
  logic [CNT_W-1:0] cnt;

  wire unused_bits = ^{strap_word, clksel_word, pll_q};

  // one restoring step
  logic [W:0]   rem_sh;
  logic [W+1:0] diff;
  logic         ge;
  logic [W-1:0] rem_nx, quo_nx;
  assign rem_sh = {rem_q, quo_q[W-1]};
  assign diff   = {1'b0, rem_sh} - {2'b00, den_q};
  assign ge     = ~diff[W+1];
  assign rem_nx = ge ? diff[W-1:0] : rem_sh[W-1:0];
  assign quo_nx = {quo_q[W-2:0], ge};

  logic [W-1:0] ref_now;
  assign ref_now = s25_q ? W'(25_000_000) : (s48_q ? W'(48_000_000) : W'(24_000_000));

  function automatic logic [W-1:0] table_hz(input logic is25, input logic [1:0] sel);
    case ({is25, sel})
      3'b000:  return W'(384_000_000);
      3'b001:  return W'(360_000_000);
      3'b010:  return W'(336_000_000);
      3'b011:  return W'(408_000_000);
      3'b100:  return W'(400_000_000);
      3'b101:  return W'(375_000_000);
      3'b110:  return W'(350_000_000);
      default: return W'(425_000_000);
    endcase
  endfunction

  logic go_full, go_bus;
  assign go_full = state == S_IDLE && (kick || start_full);
  assign go_bus  = state == S_IDLE && !kick && !start_full && start_bus;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      phase     <= PH_A;
      kick      <= 1'b1;
      busy      <= 1'b0;
      done      <= 1'b0;
      ref_hz    <= '0;
      pll_hz    <= '0;
      bus_hz    <= '0;
      variant_q <= 1'b0;
      s25_q     <= 1'b0;
      s48_q     <= 1'b0;
      hsel_q    <= '0;
      pll_q     <= '0;
      div_q     <= '0;
      quo_q     <= '0;
      rem_q     <= '0;
      den_q     <= '0;
      cnt       <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (go_full) begin
            kick      <= 1'b0;
            busy      <= 1'b1;
            variant_q <= variant;
            s25_q     <= strap_word[REF25_BIT];
            s48_q     <= strap_word[REF48_BIT];
            hsel_q    <= strap_word[HSEL_LSB +: 2];
            pll_q     <= pll_word;
            div_q     <= clksel_word[CLKDIV_LSB +: CLKDIV_W];
            state     <= S_PLL;
          end else if (go_bus) begin
            busy      <= 1'b1;
            variant_q <= variant;
            div_q     <= clksel_word[CLKDIV_LSB +: CLKDIV_W];
            state     <= S_BUS;
          end
        end
        S_PLL: begin
          ref_hz <= ref_now;
          rem_q  <= '0;
          cnt    <= '0;
          phase  <= PH_A;
          if (!variant_q) begin
            if (pll_q[V0_OFF_BIT]) begin
              pll_hz <= '0;
              state  <= S_BUS;
            end else if (pll_q[V0_PROG_BIT]) begin
              if (pll_q[V0_BYPASS_BIT]) begin
                pll_hz <= ref_now;
                state  <= S_BUS;
              end else begin
                quo_q <= W'(pll_q[10:5]) + W'(2);
                den_q <= W'(pll_q[3:0]) + W'(1);
                state <= S_DIV;
              end
            end else begin
              pll_hz <= table_hz(s25_q, hsel_q);
              state  <= S_BUS;
            end
          end else begin
            if (pll_q[V1_OFF_BIT]) begin
              pll_hz <= '0;
              state  <= S_BUS;
            end else if (pll_q[V1_BYPASS_BIT]) begin
              pll_hz <= ref_now;
              state  <= S_BUS;
            end else begin
              quo_q <= W'(pll_q[12:5]) + W'(1);
              den_q <= W'(pll_q[4:0]) + W'(1);
              state <= S_DIV;
            end
          end
        end
        S_BUS: begin
          quo_q <= pll_hz;
          rem_q <= '0;
          den_q <= W'(div_q) + W'(1);
          cnt   <= '0;
          phase <= PH_BUS;
          state <= S_DIV;
        end
        S_DIV: begin
          rem_q <= rem_nx;
          quo_q <= quo_nx;
          cnt   <= cnt + 1'b1;
          if (cnt == LAST) begin
            case (phase)
              PH_A: begin
                if (!variant_q) begin
                  pll_hz <= ref_hz * (pll_q[4] ? quo_nx : {quo_nx[W-2:0], 1'b0});
                  state  <= S_BUS;
                end else begin
                  rem_q <= '0;
                  cnt   <= '0;
                  den_q <= W'(pll_q[18:13]) + W'(1);
                  phase <= PH_B;
                end
              end
              PH_B: begin
                pll_hz <= ref_hz * quo_nx;
                state  <= S_BUS;
              end
              default: begin
                bus_hz <= variant_q ? (quo_nx >> 2) : (quo_nx >> 1);
                busy   <= 1'b0;
                done   <= 1'b1;
                state  <= S_IDLE;
              end
            endcase
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

module clkfreq_calc_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_full,
  input logic         start_bus,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] ref_hz,
  input logic [W-1:0] pll_hz,
  input logic [W-1:0] bus_hz
);

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_ends_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_done_not_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_start_accepted_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (start_full || start_bus)) |=> busy);

  assert_bus_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bus_hz) |-> done);

  assert_pll_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pll_hz) |-> $past(busy));

  assert_ref_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ref_hz == W'(24_000_000) || ref_hz == W'(25_000_000) ||
              ref_hz == W'(48_000_000)));

endmodule

bind clkfreq_calc clkfreq_calc_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_full(start_full), .start_bus(start_bus),
  .busy(busy), .done(done), .ref_hz(ref_hz), .pll_hz(pll_hz), .bus_hz(bus_hz)
);

// File: tb/clkfreq_calc_bench.sv
module clkfreq_calc_bench;
  logic clk = 0;
  logic rst_n = 0;
  logic start_full = 0, start_bus = 0, variant = 0;
  logic [31:0] strap_word = 0, pll_word = 0, clksel_word = 0;
  logic busy, done;
  logic [31:0] ref_hz, pll_hz, bus_hz;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  clkfreq_calc u_clkfreq_calc (
    .clk(clk), .rst_n(rst_n), .start_full(start_full), .start_bus(start_bus),
    .variant(variant), .strap_word(strap_word), .pll_word(pll_word),
    .clksel_word(clksel_word), .busy(busy), .done(done),
    .ref_hz(ref_hz), .pll_hz(pll_hz), .bus_hz(bus_hz));

  function automatic logic [31:0] m_ref(logic [31:0] s);
    return s[23] ? 32'd25_000_000 : (s[18] ? 32'd48_000_000 : 32'd24_000_000);
  endfunction

  function automatic logic [31:0] m_pll(logic v, logic [31:0] s, logic [31:0] p);
    logic [31:0] r, mlt, q;
    logic [31:0] tab [8];
    tab = '{384_000_000, 360_000_000, 336_000_000, 408_000_000,
            400_000_000, 375_000_000, 350_000_000, 425_000_000};
    r = m_ref(s);
    if (!v) begin
      if (p[17]) return 0;
      if (!p[19]) return tab[{s[23], s[9:8]}];
      if (p[18]) mlt = 1;
      else begin
        q = (32'(p[10:5]) + 2) / (32'(p[3:0]) + 1);
        mlt = (2 - 32'(p[4])) * q;
      end
    end else begin
      if (p[19]) return 0;
      if (p[20]) mlt = 1;
      else mlt = ((32'(p[12:5]) + 1) / (32'(p[4:0]) + 1)) / (32'(p[18:13]) + 1);
    end
    return r * mlt;
  endfunction

  function automatic logic [31:0] m_bus(logic v, logic [31:0] pll, logic [31:0] c);
    return (pll / (32'(c[25:23]) + 1)) / (v ? 4 : 2);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_done(string req);
    bit seen = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (done) begin seen = 1; break; end
    end
    chk({req, " done seen"}, 32'(seen), 1);
  endtask

  task automatic set_in(logic v, logic [31:0] s, logic [31:0] p, logic [31:0] c);
    variant = v; strap_word = s; pll_word = p; clksel_word = c;
  endtask

  task automatic pulse_full();
    start_full = 1; @(negedge clk); start_full = 0;
  endtask

  task automatic check_all(string req, logic v, logic [31:0] s, logic [31:0] p, logic [31:0] c);
    logic [31:0] ep;
    ep = m_pll(v, s, p);
    chk({req, " ref"}, ref_hz, m_ref(s));
    chk({req, " pll"}, pll_hz, ep);
    chk({req, " bus R8"}, bus_hz, m_bus(v, ep, c));
  endtask

  task automatic run_full(string req, logic v, logic [31:0] s, logic [31:0] p, logic [31:0] c);
    @(negedge clk);
    set_in(v, s, p, c);
    pulse_full();
    chk("R11 busy after start", 32'(busy), 1);
    wait_done(req);
    chk("R11 busy low at done", 32'(busy), 0);
    check_all(req, v, s, p, c);
    @(negedge clk);
    chk("R11 done single cycle", 32'(done), 0);
  endtask

  task automatic t_reset();
    set_in(0, 32'h0, 32'h0008_0000 | (30 << 5) | 3, 32'(2) << 23);
    @(negedge clk);
    chk("R1 reset ref", ref_hz, 0);
    chk("R1 reset pll", pll_hz, 0);
    chk("R1 reset bus", bus_hz, 0);
    chk("R1 reset busy", 32'(busy), 0);
    chk("R1 reset done", 32'(done), 0);
    rst_n = 1;
    wait_done("R1 auto");
    check_all("R1 auto R4", 0, 32'h0, 32'h0008_0000 | (30 << 5) | 3, 32'(2) << 23);
  endtask

  task automatic t_ref();
    run_full("R2 48M", 1, 32'h0004_0000, 32'h0010_0000, 0);
    run_full("R2 both", 1, 32'h0084_0000, 32'h0010_0000, 0);
    run_full("R2 24M", 1, 32'h0, 32'h0010_0000, 0);
  endtask

  task automatic t_v0();
    run_full("R3 off", 0, 32'h0, 32'hFFFF_FFFF, 32'(5) << 23);
    run_full("R4 bypass", 0, 32'h0080_0000, 32'h000C_0000, 32'(1) << 23);
    run_full("R4 trunc od", 0, 32'h0, 32'h0008_0000 | (5 << 5) | (1 << 4) | 2, 0);
    run_full("R5 table24", 0, 32'h0000_0200, 32'h0, 32'(3) << 23);
    run_full("R5 table25", 0, 32'h0080_0300, 32'h0, 32'(7) << 23);
    run_full("R5 table48", 0, 32'h0004_0100, 32'h0, 0);
  endtask

  task automatic t_v1();
    run_full("R6 off", 1, 32'h0, 32'h0008_0000 | 32'hFFFF, 0);
    run_full("R6 bypass", 1, 32'h0080_0000, 32'h0010_0000, 32'(2) << 23);
    run_full("R6 formula", 1, 32'h0080_0000, (1 << 13) | (95 << 5) | 1, 32'(1) << 23);
    run_full("R7 wrap", 1, 32'h0080_0000, (255 << 5), 0);
    chk("R7 wrap value", pll_hz, 32'd2105032704);
  endtask

  task automatic t_bus_only();
    logic [31:0] held;
    run_full("R9 setup", 0, 32'h0, 32'h0008_0000 | (30 << 5) | 3, 0);
    held = pll_hz;
    @(negedge clk);
    pll_word = 32'h0002_0000; strap_word = 32'h0080_0000; clksel_word = 32'(4) << 23;
    start_bus = 1; @(negedge clk); start_bus = 0;
    wait_done("R9");
    chk("R9 pll held", pll_hz, held);
    chk("R9 ref held", ref_hz, 32'd24_000_000);
    chk("R9 bus recomputed R8", bus_hz, m_bus(0, held, 32'(4) << 23));
  endtask

  task automatic t_busy_ignore();
    int extra = 0;
    logic [31:0] pa = 32'h0008_0000 | (10 << 5) | 1;
    @(negedge clk);
    set_in(0, 32'h0, pa, 32'(1) << 23);
    pulse_full();
    repeat (5) @(negedge clk);
    pll_word = 32'h0002_0000;
    pulse_full();
    start_bus = 1; @(negedge clk); start_bus = 0;
    wait_done("R10");
    chk("R10 first start kept", pll_hz, m_pll(0, 32'h0, pa));
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (done) extra++;
    end
    chk("R10 no extra done", 32'(extra), 0);
    @(negedge clk);
    set_in(1, 32'h0080_0000, 32'h0010_0000, 32'(3) << 23);
    start_full = 1; start_bus = 1; @(negedge clk); start_full = 0; start_bus = 0;
    wait_done("R10 both");
    check_all("R10 full wins", 1, 32'h0080_0000, 32'h0010_0000, 32'(3) << 23);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_ref();
    t_v0();
    t_v1();
    t_bus_only();
    t_busy_ignore();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule